// File: doc/BRIEF.md
# DDR SDRAM Refresh Scheduler with Postponement

This block decides when a four-bank DDR SDRAM is owed an auto-refresh and asks the command arbiter for a slot to issue it. A free-running interval counter adds one refresh credit each time the average refresh period (7.8 µs, so that 8K refreshes cover 64 ms) has elapsed. Credits pile up while the arbiter is busy with other traffic, up to a hard ceiling of eight postponed refreshes. At that ceiling the scheduler flags the request as urgent.

A request is raised only when at least one credit is owed, every bank is precharged, and no earlier refresh is still completing. Each grant consumes one credit and opens an activation-block window of the refresh cycle time (120 ns). Self refresh is driven by entry and exit strobes. Entry wipes the credit count and freezes the interval counter. Exit opens two hold-off windows: a short one (75 ns) for ordinary commands and a long one (200 clocks) for reads. All nanosecond figures are parameters that the block converts to clock cycles, rounding up.

Top module: `rfsh_sched`

## Requirements
- R1: After reset or after leaving self refresh, the interval counter starts from zero, and one credit is added on every IV-th rising edge, where IV = ceil(TREFI_NS*1000/TCK_PS). The first request therefore appears IV edges after reset release.
- R2: The credit count never exceeds MAX_OWED (8). Credits arriving while the count is full are lost. rf_urgent is high exactly while the count equals MAX_OWED and falls once a grant lowers it.
- R3: rf_req is low whenever banks_idle is low. A pending credit is kept and is requested again once banks_idle returns high.
- R4: A grant taken while rf_req is high removes one credit. rf_req stays low once the count is zero.
- R5: From the edge that takes a grant, act_block is high for RFC = ceil(TRFC_NS*1000/TCK_PS) samples, and rf_req is low for that whole time.
- R6: A grant while rf_req is low has no effect: no credit is taken and act_block stays low.
- R7: An sr_enter pulse while running sets in_selfref on the next edge, clears all owed credits and holds the interval counter. No credit accumulates while in self refresh, and rf_req stays low.
- R8: An sr_exit pulse while in self refresh clears in_selfref. cmd_ready is then low for XSNR = ceil(TXSNR_NS*1000/TCK_PS) samples and rd_ready is low for TXSRD_CK samples. Both are low throughout self refresh. sr_exit has no effect while running.
- R9: During and just after reset, rf_req, rf_urgent, act_block and in_selfref are low, and cmd_ready and rd_ready are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| banks_idle | input | 1 | All four banks are precharged |
| rf_grant | input | 1 | Arbiter issues the refresh this cycle |
| sr_enter | input | 1 | Self-refresh entry strobe |
| sr_exit | input | 1 | Self-refresh exit strobe |
| rf_req | output | 1 | Refresh request to the arbiter |
| rf_urgent | output | 1 | Maximum postponement reached |
| act_block | output | 1 | Refresh cycle time running; no row activation |
| cmd_ready | output | 1 | Non-read commands allowed |
| rd_ready | output | 1 | Read commands allowed |
| in_selfref | output | 1 | Device is in self refresh |

## Verification
A wrong credit count shows up at the ports as the wrong number of grants needed to drain the backlog, or as rf_urgent rising on an edge other than the eighth interval. Either appears within one interval of the fault. A phase error in the interval counter moves the first rf_req after reset or after a self-refresh exit away from the exact edge expected. A mis-sized or mis-loaded window changes how many samples act_block, cmd_ready or rd_ready stay in their blocking state, which is visible within a few cycles of the grant or exit. A credit that leaks through self refresh produces an early rf_req after the exit.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    // Integer division rounded toward +infinity, used to turn times into cycles.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_SELF = 1'b1
    } rf_mode_e;

endpackage

// File: rtl/rfsh_tick_gen.sv
module rfsh_tick_gen #(
    parameter int PERIOD = 1040
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    logic [W-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end

    // R1: the phase counter stays inside one interval
    a_r1_phase_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/rfsh_credit.sv
module rfsh_credit #(
    parameter int MAX_OWED = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             add,
    input  logic                             take,
    input  logic                             clear,
    output logic [$clog2(MAX_OWED+1)-1:0]    owed,
    output logic                             full
);
    localparam int OW = $clog2(MAX_OWED + 1);
    localparam logic [OW:0] MAXV = (OW+1)'(MAX_OWED);

    logic [OW:0] nxt;

    always_comb begin
        nxt = {1'b0, owed};
        if (add) nxt = nxt + 1'b1;
        if (take && (nxt != '0)) nxt = nxt - 1'b1;
        if (nxt > MAXV) nxt = MAXV;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) owed <= '0;
        else              owed <= nxt[OW-1:0];
    end

    assign full = (owed == MAXV[OW-1:0]);

    // R2: never more than the postponement ceiling
    a_r2_owed_bound: assert property (@(posedge clk) disable iff (rst)
        owed <= MAXV[OW-1:0]);

    // R4: a grant alone removes exactly one credit
    a_r4_take_dec: assert property (@(posedge clk) disable iff (rst)
        (take && !add && !clear && owed != '0) |=> owed == $past(owed) - 1'b1);

    // R1: a credit alone below the ceiling adds exactly one
    a_r1_add_inc: assert property (@(posedge clk) disable iff (rst)
        (add && !take && !clear && !full) |=> owed == $past(owed) + 1'b1);

endmodule

// File: rtl/rfsh_window.sv
module rfsh_window #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic active
);
    localparam int W = $clog2(LEN + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= W'(LEN);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);

    // R5 / R8: an open window shrinks by one each cycle
    a_r5_window_step: assert property (@(posedge clk) disable iff (rst)
        (active && !load) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int TCK_PS   = 7500,
    parameter int TREFI_NS = 7800,
    parameter int TRFC_NS  = 120,
    parameter int TXSNR_NS = 75,
    parameter int TXSRD_CK = 200,
    parameter int MAX_OWED = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic banks_idle,
    input  logic rf_grant,
    input  logic sr_enter,
    input  logic sr_exit,
    output logic rf_req,
    output logic rf_urgent,
    output logic act_block,
    output logic cmd_ready,
    output logic rd_ready,
    output logic in_selfref
);
    localparam int IV_CYC   = ceil_div(TREFI_NS * 1000, TCK_PS);
    localparam int RFC_CYC  = ceil_div(TRFC_NS * 1000, TCK_PS);
    localparam int XSNR_CYC = ceil_div(TXSNR_NS * 1000, TCK_PS);
    localparam int OW       = $clog2(MAX_OWED + 1);

    rf_mode_e      mode;
    logic          enter_acc, exit_acc;
    logic          tick, take, full;
    logic [OW-1:0] owed;
    logic          xsnr_busy, xsrd_busy;

    assign enter_acc = sr_enter && (mode == MODE_RUN);
    assign exit_acc  = sr_exit  && (mode == MODE_SELF);

    always_ff @(posedge clk) begin
        if (rst)            mode <= MODE_RUN;
        else if (enter_acc) mode <= MODE_SELF;
        else if (exit_acc)  mode <= MODE_RUN;
    end

    rfsh_tick_gen #(.PERIOD(IV_CYC)) tick_i (
        .clk   (clk),
        .rst   (rst),
        .run   (mode == MODE_RUN),
        .clear (enter_acc),
        .tick  (tick)
    );

    rfsh_credit #(.MAX_OWED(MAX_OWED)) credit_i (
        .clk   (clk),
        .rst   (rst),
        .add   (tick),
        .take  (take),
        .clear (enter_acc),
        .owed  (owed),
        .full  (full)
    );

    rfsh_window #(.LEN(RFC_CYC)) rfc_win_i (
        .clk    (clk),
        .rst    (rst),
        .load   (take),
        .active (act_block)
    );

    rfsh_window #(.LEN(XSNR_CYC)) xsnr_win_i (
        .clk    (clk),
        .rst    (rst),
        .load   (exit_acc),
        .active (xsnr_busy)
    );

    rfsh_window #(.LEN(TXSRD_CK)) xsrd_win_i (
        .clk    (clk),
        .rst    (rst),
        .load   (exit_acc),
        .active (xsrd_busy)
    );

    assign in_selfref = (mode == MODE_SELF);
    assign cmd_ready  = !in_selfref && !xsnr_busy;
    assign rd_ready   = !in_selfref && !xsrd_busy;
    assign rf_req     = (owed != '0) && banks_idle && !act_block && cmd_ready;
    assign rf_urgent  = full;
    assign take       = rf_grant && rf_req;

    // R5: a taken grant always opens the activation block
    a_r5_grant_busy: assert property (@(posedge clk) disable iff (rst)
        (rf_grant && rf_req) |=> act_block);

    // R7: no credit is held while the device refreshes itself
    a_r7_sr_no_credit: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SELF) |-> (owed == '0));

    // R8: the read hold-off outlasts the ordinary one
    a_r8_rd_after_cmd: assert property (@(posedge clk) disable iff (rst)
        rd_ready |-> cmd_ready);

endmodule

// File: tb/rfsh_sched_tb_top.sv
module rfsh_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IV  = 20;   // 200 ns / 10 ns
    localparam int RFC = 4;    // ceil(35 ns / 10 ns)
    localparam int XSN = 3;    // ceil(25 ns / 10 ns)
    localparam int XSR = 12;
    localparam int MAXO = 8;

    logic clk = 1'b0;
    logic rst, banks_idle, rf_grant, sr_enter, sr_exit;
    logic rf_req, rf_urgent, act_block, cmd_ready, rd_ready, in_selfref;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rfsh_sched #(
        .TCK_PS(10000), .TREFI_NS(200), .TRFC_NS(35),
        .TXSNR_NS(25), .TXSRD_CK(XSR), .MAX_OWED(MAXO)
    ) dut_i (
        .clk(clk), .rst(rst), .banks_idle(banks_idle), .rf_grant(rf_grant),
        .sr_enter(sr_enter), .sr_exit(sr_exit), .rf_req(rf_req),
        .rf_urgent(rf_urgent), .act_block(act_block), .cmd_ready(cmd_ready),
        .rd_ready(rd_ready), .in_selfref(in_selfref)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        cyc++;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
        $finish;
    end

    initial begin
        int n, g, added, lc, lr, reqat;
        rst = 1'b1; banks_idle = 1'b1; rf_grant = 1'b0; sr_enter = 1'b0; sr_exit = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset req", rf_req, 0);
        rst = 1'b0;
        cyc = 0;
        #1;
        chk("R9 urgent", rf_urgent, 0);
        chk("R9 act_block", act_block, 0);
        chk("R9 cmd_ready", cmd_ready, 1);
        chk("R9 rd_ready", rd_ready, 1);
        chk("R9 in_selfref", in_selfref, 0);

        // R1: first credit after exactly IV edges
        n = 0;
        while (!rf_req && n < 100) begin tick(); n++; end
        chk("R1 first request edge", cyc, IV);
        chk("R1 not urgent", rf_urgent, 0);

        // R4/R5: grant consumes the credit and opens the busy window
        rf_grant = 1'b1; tick(); rf_grant = 1'b0;
        chk("R5 busy after grant", act_block, 1);
        chk("R4 request drops at zero", rf_req, 0);
        n = 0;
        while (act_block && n < 50) begin n++; tick(); end
        chk("R5 busy length rounded up", n, RFC);

        // R2: urgency after eight withheld credits (edges 40..180)
        while (!rf_urgent && cyc < 400) tick();
        chk("R2 urgent edge", cyc, 9 * IV);
        repeat (45) tick();
        chk("R2 urgent held at ceiling", rf_urgent, 1);

        // R2/R4: drain; overflowed credits must be lost
        g = 0; added = 0; n = 0;
        while (n < 300) begin
            n++;
            if (rf_req) begin
                rf_grant = 1'b1; tick(); rf_grant = 1'b0;
                g++;
                if (cyc % IV == 0) added++;
                if (g == 1) chk("R2 urgent falls after grant", rf_urgent, 0);
                chk("R5 req low while busy", rf_req, 0);
            end else if (act_block) begin
                tick();
                if (cyc % IV == 0) added++;
            end else begin
                break;
            end
        end
        chk("R2 R4 grants to drain", g, MAXO + added);

        // R3 / R6: idle gating and ignored grant
        n = 0;
        while (!rf_req && n < 100) begin tick(); n++; end
        banks_idle = 1'b0; #1;
        chk("R3 req low when banks busy", rf_req, 0);
        rf_grant = 1'b1; tick(); rf_grant = 1'b0;
        chk("R6 grant without request ignored", act_block, 0);
        banks_idle = 1'b1; #1;
        chk("R3 credit kept", rf_req, 1);

        // R7: self-refresh entry with credit owed
        sr_enter = 1'b1; tick(); sr_enter = 1'b0;
        chk("R7 in_selfref", in_selfref, 1);
        chk("R7 req low", rf_req, 0);
        chk("R8 cmd blocked in self refresh", cmd_ready, 0);
        repeat (5 * IV) tick();
        chk("R7 still no req", rf_req, 0);
        chk("R7 not urgent", rf_urgent, 0);

        // R8 / R7: exit windows and fresh interval
        sr_exit = 1'b1; tick(); sr_exit = 1'b0;
        chk("R8 in_selfref cleared", in_selfref, 0);
        lc = 0; lr = 0; reqat = -1;
        for (int i = 0; i < 60; i++) begin
            if (!cmd_ready) lc++;
            if (!rd_ready) lr++;
            if (rf_req && reqat < 0) reqat = i;
            tick();
        end
        chk("R8 ordinary hold-off", lc, XSN);
        chk("R8 read hold-off", lr, XSR);
        chk("R7 R1 first credit after exit", reqat, IV);

        // R8: exit strobe ignored while running
        sr_exit = 1'b1; tick(); sr_exit = 1'b0;
        chk("R8 stray exit cmd_ready", cmd_ready, 1);
        chk("R8 stray exit rd_ready", rd_ready, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule